// File: doc/BRIEF.md
# Processor Mode and Status Flag Register

This block holds the 32-bit status word of a processor core that runs in either a supervisor mode or a user mode. The low byte carries four arithmetic flags and four control bits. The 24 bits above them are kept exactly as software last wrote them, and they serve as a trap code. The mode is the interrupt-enable bit and nothing else. With interrupts enabled the core runs user code. With them disabled the core is in supervisor mode.

Each cycle the block combines several update sources into the next value of the register:
- ALU flags from a retiring instruction.
- An explicit write of the whole register.
- An interrupt request.
- A break indication.
- An instruction-retired strobe, which ends a single-stepped user instruction.

It also evaluates the 3-bit condition field of the instruction being issued against the stored flags. It reports whether the core should wait for an interrupt, halt outright, or stop for an external debugger.

Top module: `mode_flag_reg`

## Requirements
- R1: After reset all 32 status bits read 0, so the core is in supervisor mode with no trap code.
- R2: Bit layout: bit 0 Z, bit 1 C, bit 2 N, bit 3 V, bit 4 SLEEP, bit 5 GIE, bit 6 STEP, bit 7 BREAKEN, bits 31..8 trap code. `user_mode` equals GIE. A write made in supervisor mode (GIE=0) loads all 32 bits, and the new value is visible on the cycle after the write.
- R3: An interrupt request while GIE=1 clears GIE, STEP and SLEEP on the next cycle. While GIE=0 the request has no effect on the register.
- R4: `wait_irq` is high when SLEEP=1 and GIE=1. `halt_req` is high when SLEEP=1 and GIE=0. Both come straight from the stored register.
- R5: When STEP=1 and GIE=1, the first retire strobe clears both GIE and STEP, which returns the core to supervisor mode. When GIE=0, a set STEP bit does not react to retire strobes.
- R6: A write made in user mode leaves STEP and BREAKEN at their previous values.
- R7: A break with BREAKEN=0 sets STEP and clears GIE. A break with BREAKEN=1 raises `dbg_halt` in the same cycle and leaves the register unchanged.
- R8: Bits 31..8 change only through a write, and `trap_code` shows them. A user-mode write that clears GIE moves the core to supervisor mode.
- R9: `cond_pass` follows `cond_code`: 0 always passes, 1 passes on Z, 2 on not Z, 3 on not N, 4 on neither N nor Z, 5 on N, 6 on C, 7 on V.
- R10: The flags take `alu_flags` only when `retire`, `retire_sets_flags` and `retire_cond_ok` are all high.
- R11: An explicit write in the same cycle as an ALU flag update wins. The flags take the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Explicit write of the status register |
| wr_data | input | 32 | Value for an explicit write |
| retire | input | 1 | An instruction retires this cycle |
| retire_sets_flags | input | 1 | The retiring instruction produces flags |
| retire_cond_ok | input | 1 | The retiring instruction's condition was true |
| alu_flags | input | 4 | New flags {V,N,C,Z} from the ALU |
| irq | input | 1 | Interrupt request |
| brk | input | 1 | A break instruction reached execution |
| cond_code | input | 3 | Condition field of the instruction being issued |
| status | output | 32 | Current register value |
| trap_code | output | 24 | Bits 31..8 of the register |
| user_mode | output | 1 | Core is in user mode |
| wait_irq | output | 1 | Sleep until an interrupt arrives |
| halt_req | output | 1 | Halt completely |
| dbg_halt | output | 1 | Break with debugger stop enabled |
| cond_pass | output | 1 | Condition field is satisfied |

## Verification
Every register update lands one clock edge after its stimulus. For a write, a flag update, an interrupt, a step completion or a break, `status`, `trap_code`, `user_mode`, `wait_irq` and `halt_req` are due in the cycle after the inputs are held. `cond_pass` and `dbg_halt` are combinational and are due in the cycle the inputs are driven.

The bench drives inputs just after a falling edge. It samples combinational results a moment later, before the next rising edge. It samples registered results at the falling edge that follows that rising edge, then releases the inputs.

// File: rtl/msr_pkg.sv
// Package: shared bit positions and the condition encoding for the status register.
// Assumes the 8-bit control/flag byte sits at the bottom of the register.
package msr_pkg;
    localparam int CTRL_W  = 8;
    localparam int B_Z     = 0;
    localparam int B_C     = 1;
    localparam int B_N     = 2;
    localparam int B_V     = 3;
    localparam int B_SLEEP = 4;
    localparam int B_GIE   = 5;
    localparam int B_STEP  = 6;
    localparam int B_BRKEN = 7;

    typedef enum logic [2:0] {
        COND_ALWAYS = 3'd0,
        COND_EQ     = 3'd1,
        COND_NE     = 3'd2,
        COND_GE     = 3'd3,
        COND_GT     = 3'd4,
        COND_LT     = 3'd5,
        COND_CS     = 3'd6,
        COND_VS     = 3'd7
    } cond_e;
endpackage

// File: rtl/msr_cond_eval.sv
// Module: evaluates a 3-bit instruction condition against stored flags {V,N,C,Z}.
// Assumes the flags are stable for the cycle; purely combinational.
module msr_cond_eval
    import msr_pkg::*;
(
    input  logic [3:0] flags,
    input  logic [2:0] code,
    output logic       pass
);
    logic fz, fc, fn, fv;
    assign fz = flags[B_Z];
    assign fc = flags[B_C];
    assign fn = flags[B_N];
    assign fv = flags[B_V];

    // Select the pass term for the requested condition.
    always_comb begin
        case (cond_e'(code))
            COND_ALWAYS: pass = 1'b1;
            COND_EQ:     pass = fz;
            COND_NE:     pass = !fz;
            COND_GE:     pass = !fn;
            COND_GT:     pass = !fn && !fz;
            COND_LT:     pass = fn;
            COND_CS:     pass = fc;
            COND_VS:     pass = fv;
            default:     pass = 1'b0;
        endcase
    end
endmodule

// File: rtl/msr_next_state.sv
// Module: merges all update sources into the next status value.
// Precedence, lowest to highest: ALU flags, explicit write, step completion,
// interrupt entry, break. Assumes a break never coincides with a retire.
module msr_next_state
    import msr_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] cur,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         retire,
    input  logic         flag_upd,
    input  logic [3:0]   alu_flags,
    input  logic         irq,
    input  logic         brk,
    output logic [W-1:0] nxt,
    output logic         dbg_halt
);
    logic in_user;
    assign in_user = cur[B_GIE];

    // Apply each update source in precedence order.
    always_comb begin
        nxt      = cur;
        dbg_halt = 1'b0;
        if (flag_upd) begin
            nxt[3:0] = alu_flags;
        end
        if (wr_en) begin
            nxt = wr_data;
            if (in_user) begin
                nxt[B_STEP]  = cur[B_STEP];
                nxt[B_BRKEN] = cur[B_BRKEN];
            end
        end
        if (in_user && cur[B_STEP] && retire) begin
            nxt[B_GIE]  = 1'b0;
            nxt[B_STEP] = 1'b0;
        end
        if (in_user && irq) begin
            nxt[B_GIE]   = 1'b0;
            nxt[B_STEP]  = 1'b0;
            nxt[B_SLEEP] = 1'b0;
        end
        if (brk) begin
            if (cur[B_BRKEN]) begin
                dbg_halt = 1'b1;
            end else begin
                nxt[B_GIE]  = 1'b0;
                nxt[B_STEP] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/msr_state_reg.sv
// Module: the status register storage with synchronous active-low clear.
// Assumes reset is held for at least one rising edge.
module msr_state_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Hold the status word; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/mode_flag_reg.sv
// Module: processor mode and status flag register (top).
// Holds the status word, decodes conditions and drives the sleep, halt and
// debug-stop requests. Assumes single-cycle strobes on irq, brk and retire.
module mode_flag_reg
    import msr_pkg::*;
#(
    parameter int W = 32,
    localparam int TRAP_W = W - CTRL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [W-1:0]      wr_data,
    input  logic              retire,
    input  logic              retire_sets_flags,
    input  logic              retire_cond_ok,
    input  logic [3:0]        alu_flags,
    input  logic              irq,
    input  logic              brk,
    input  logic [2:0]        cond_code,
    output logic [W-1:0]      status,
    output logic [TRAP_W-1:0] trap_code,
    output logic              user_mode,
    output logic              wait_irq,
    output logic              halt_req,
    output logic              dbg_halt,
    output logic              cond_pass
);
    logic [W-1:0] nxt;
    logic         flag_upd;

    assign flag_upd = retire && retire_sets_flags && retire_cond_ok;

    msr_next_state #(.W(W)) u_next (
        .cur       (status),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .retire    (retire),
        .flag_upd  (flag_upd),
        .alu_flags (alu_flags),
        .irq       (irq),
        .brk       (brk),
        .nxt       (nxt),
        .dbg_halt  (dbg_halt)
    );

    msr_state_reg #(.W(W)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (nxt),
        .q     (status)
    );

    msr_cond_eval u_cond (
        .flags (status[3:0]),
        .code  (cond_code),
        .pass  (cond_pass)
    );

    assign trap_code = status[W-1:CTRL_W];
    assign user_mode = status[B_GIE];
    assign wait_irq  = status[B_SLEEP] && status[B_GIE];
    assign halt_req  = status[B_SLEEP] && !status[B_GIE];
endmodule

// File: rtl/msr_checker.sv
// Module: temporal checks on the status register, bound to the top module.
// Assumes the same clock and reset as the block it observes.
module msr_checker #(
    parameter int W = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [W-1:0]  wr_data,
    input logic          retire,
    input logic          retire_sets_flags,
    input logic          retire_cond_ok,
    input logic [3:0]    alu_flags,
    input logic          irq,
    input logic          brk,
    input logic [W-1:0]  status,
    input logic [W-9:0]  trap_code,
    input logic          user_mode,
    input logic          wait_irq,
    input logic          halt_req
);
    assert_irq_enters_super_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (user_mode && irq) |=> (!user_mode && !status[4] && !status[6]));

    assert_sleep_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({halt_req, wait_irq}));

    assert_step_returns_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (user_mode && status[6] && retire && !brk) |=> (!user_mode && !status[6]));

    assert_user_write_keeps_ctrl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (user_mode && wr_en && !brk && !retire && !irq) |=> (status[7:6] == $past(status[7:6])));

    assert_break_sets_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (brk && !status[7]) |=> (status[6] && !user_mode));

    assert_trap_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(trap_code));

    assert_flag_update_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && retire_sets_flags && retire_cond_ok && !wr_en) |=> (status[3:0] == $past(alu_flags)));

    assert_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (status[3:0] == $past(wr_data[3:0])));
endmodule

bind mode_flag_reg msr_checker #(.W(W)) u_msr_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .wr_en             (wr_en),
    .wr_data           (wr_data),
    .retire            (retire),
    .retire_sets_flags (retire_sets_flags),
    .retire_cond_ok    (retire_cond_ok),
    .alu_flags         (alu_flags),
    .irq               (irq),
    .brk               (brk),
    .status            (status),
    .trap_code         (trap_code),
    .user_mode         (user_mode),
    .wait_irq          (wait_irq),
    .halt_req          (halt_req)
);

// File: tb/tb_mode_flag_reg.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_mode_flag_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en, retire, retire_sets_flags, retire_cond_ok, irq, brk;
    logic [31:0] wr_data;
    logic [3:0]  alu_flags;
    logic [2:0]  cond_code;
    logic [31:0] status;
    logic [23:0] trap_code;
    logic        user_mode, wait_irq, halt_req, dbg_halt, cond_pass;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #10 clk = ~clk;

    mode_flag_reg dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .retire(retire), .retire_sets_flags(retire_sets_flags),
        .retire_cond_ok(retire_cond_ok), .alu_flags(alu_flags), .irq(irq),
        .brk(brk), .cond_code(cond_code), .status(status), .trap_code(trap_code),
        .user_mode(user_mode), .wait_irq(wait_irq), .halt_req(halt_req),
        .dbg_halt(dbg_halt), .cond_pass(cond_pass)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        wr_en = 0; wr_data = '0; retire = 0; retire_sets_flags = 0;
        retire_cond_ok = 0; alu_flags = '0; irq = 0; brk = 0;
    endtask

    // Hold driven inputs across one rising edge, then release at the falling edge.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic wr(input logic [31:0] d);
        wr_en = 1; wr_data = d;
        tick();
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle_inputs();
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    function automatic logic exp_cond(input logic [2:0] c, input logic [3:0] f);
        case (c)
            3'd0: return 1'b1;
            3'd1: return f[0];
            3'd2: return !f[0];
            3'd3: return !f[2];
            3'd4: return !f[2] && !f[0];
            3'd5: return f[2];
            3'd6: return f[1];
            default: return f[3];
        endcase
    endfunction

    task automatic t_reset();
        do_reset();
        chk("R1 status", status, 32'h0);
        chk("R1 user_mode", {31'h0, user_mode}, 32'h0);
        chk("R1 trap", {8'h0, trap_code}, 32'h0);
    endtask

    task automatic t_super_write();
        do_reset();
        wr(32'hABCDE0C5);
        chk("R2 status", status, 32'hABCDE0C5);
        chk("R8 trap", {8'h0, trap_code}, 32'h00ABCDE0);
        chk("R2 mode", {31'h0, user_mode}, 32'h0);
    endtask

    task automatic t_cond();
        do_reset();
        for (int f = 0; f < 16; f++) begin
            wr({28'h0, f[3:0]});
            for (int c = 0; c < 8; c++) begin
                cond_code = c[2:0];
                #1;
                chk("R9 cond", {31'h0, cond_pass}, {31'h0, exp_cond(c[2:0], f[3:0])});
            end
        end
    endtask

    task automatic t_flags();
        do_reset();
        retire = 1; retire_sets_flags = 1; retire_cond_ok = 1; alu_flags = 4'hA; tick();
        chk("R10 update", status, 32'h0A);
        retire = 1; retire_sets_flags = 1; retire_cond_ok = 0; alu_flags = 4'h5; tick();
        chk("R10 cond false", status, 32'h0A);
        retire = 1; retire_sets_flags = 0; retire_cond_ok = 1; alu_flags = 4'h5; tick();
        chk("R10 no flags", status, 32'h0A);
        retire = 0; retire_sets_flags = 1; retire_cond_ok = 1; alu_flags = 4'h5; tick();
        chk("R10 no retire", status, 32'h0A);
        retire = 1; retire_sets_flags = 1; retire_cond_ok = 1; alu_flags = 4'h5;
        wr_en = 1; wr_data = 32'h03; tick();
        chk("R11 write wins", status, 32'h03);
    endtask

    task automatic t_irq();
        do_reset();
        irq = 1; tick();
        chk("R3 super ignores", status, 32'h0);
        wr(32'h2F);
        chk("R2 user", {31'h0, user_mode}, 32'h1);
        irq = 1; tick();
        chk("R3 irq entry", status, 32'h0F);
        wr(32'h60);
        irq = 1; tick();
        chk("R3 clears step", status, 32'h00);
    endtask

    task automatic t_sleep();
        do_reset();
        wr(32'h30);
        chk("R4 wait", {30'h0, wait_irq, halt_req}, 32'h2);
        irq = 1; tick();
        chk("R3 wake", status, 32'h00);
        wr(32'h10);
        chk("R4 halt", {30'h0, wait_irq, halt_req}, 32'h1);
    endtask

    task automatic t_step();
        do_reset();
        wr(32'h60);
        chk("R5 enter user", status, 32'h60);
        tick();
        chk("R5 no retire", status, 32'h60);
        retire = 1; tick();
        chk("R5 one shot", status, 32'h00);
        wr(32'h40);
        retire = 1; tick();
        chk("R5 super no effect", status, 32'h40);
    endtask

    task automatic t_user_write();
        do_reset();
        wr(32'h20);
        wr(32'hE0);
        chk("R6 ctrl kept", status, 32'h20);
        wr(32'h00000A03);
        chk("R8 trap entry", status, 32'h00000A03);
        chk("R8 trap code", {8'h0, trap_code}, 32'h0000000A);
    endtask

    task automatic t_break();
        do_reset();
        wr(32'h20);
        brk = 1;
        #1;
        chk("R7 no dbg halt", {31'h0, dbg_halt}, 32'h0);
        tick();
        chk("R7 break step", status, 32'h40);
        do_reset();
        wr(32'hA0);
        brk = 1;
        #1;
        chk("R7 dbg halt", {31'h0, dbg_halt}, 32'h1);
        tick();
        chk("R7 unchanged", status, 32'hA0);
    endtask

    initial begin
        idle_inputs();
        cond_code = '0;
        t_reset();
        t_super_write();
        t_cond();
        t_flags();
        t_irq();
        t_sleep();
        t_step();
        t_user_write();
        t_break();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            nchk++;
            nerr++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end
endmodule